// File: doc/BRIEF.md
# Banked Secure Interrupt Controller

This block collects 128 level-sensitive interrupt sources, arranged as four banks of 32, and turns them into three outputs: a normal interrupt request, a fast interrupt request and a wake request for the power controller. Source `n` belongs to bank `n>>5` at bit `n&31`. Software programs the block through a small register port that has an address, write data, a write strobe and combinational read data.

Each source has an enable bit. Software changes the enable bits through a pair of write-one registers, one that sets bits and one that clears them, so no read-modify-write is needed. A per-source routing bit sends the source either to the normal output or to the fast output. The pending registers show every source that is both asserted and enabled. Before deep sleep, software arms a holdoff flag and loads wake masks. While the flag is set, any masked source that is high raises the wake request.

The source lines pass through a two-stage synchronizer. A change on a source shows up in the pending registers two clocks later and on the registered outputs three clocks later.

Top module: `banked_intc`

## Requirements
- R1: Source `n` is bank `n>>5`, bit `n&31`. The pending register of bank `b` (offset 0xD80+4b) reads the synchronized source lines ANDed with the enable mask. It reflects a change on a source after two clock edges.
- R2: A write to 0x100+4b sets every enable bit of bank `b` whose write-data bit is 1, and leaves the bits written 0 unchanged. A read of this offset returns the bank's current enable mask.
- R3: A write to 0x180+4b clears every enable bit of bank `b` whose write-data bit is 1, and leaves the bits written 0 unchanged. A read of this offset also returns the current enable mask.
- R4: The routing register at 0x080+4b is read/write. A bit value of 1 routes the source to `irq_o` and 0 routes it to `fiq_o`. Reset sets every routing bit to 1.
- R5: `irq_o` is a register that holds the OR, over all banks, of pending AND routing, taken one clock earlier.
- R6: `fiq_o` is a register that holds the OR, over all banks, of pending AND NOT routing, taken one clock earlier.
- R7: The wake mask register at 0xE00+4b is read/write and resets to 0.
- R8: Writing to offset 0x014 with bit 0 at 1 sets the holdoff flag, and writing with bit 0 at 0 clears it. A read returns 1 while the flag is set and 0 otherwise.
- R9: `wake_o` is a register that holds the holdoff flag ANDed with the OR of the synchronized sources masked by their wake bits, taken one clock earlier.
- R10: The offsets 0x000, 0x00C and 0x010 are 32-bit read/write storage. Each reads back the value last written to it and resets to 0.
- R11: A read of an unmapped offset returns 0. This covers misaligned addresses and bank slots at or beyond the configured bank count. A write to an unmapped offset changes no state.
- R12: After reset, all enable bits, wake masks, the holdoff flag and all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W (12) | Register byte address |
| reg_wdata | input | BANK_W (32) | Register write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | BANK_W (32) | Combinational read data for `reg_addr` |
| src_i | input | NUM_BANKS*BANK_W (128) | Raw level-sensitive source lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request while holdoff is armed |

## Verification
The bench measures the synchronizer latency one cycle at a time. A design with one stage too many or too few would show the pending bit or `irq_o` a cycle early or late. It writes data words with both 0 and 1 bits to the set and clear registers. A design that treated the written word as a full value, instead of a bit mask, would lose enable bits that should have stayed unchanged. Sources that are routed to the fast output must leave `irq_o` low. The bench arms and disarms holdoff while sources matching the wake mask are high, so a wake request that ignores the flag shows up. Misaligned addresses, out-of-range bank slots and global gaps are read and written, so a loose decoder that aliases them onto real registers fails.

// File: rtl/bintc_pkg.sv
`timescale 1ns/1ps
package bintc_pkg;

   // Register offsets software depends on (byte addresses)
   localparam logic [15:0] OFS_CTRL  = 16'h0000;
   localparam logic [15:0] OFS_PRIO  = 16'h000C;
   localparam logic [15:0] OFS_SYNC  = 16'h0010;
   localparam logic [15:0] OFS_HOLD  = 16'h0014;
   localparam logic [15:0] OFS_SEL   = 16'h0080;
   localparam logic [15:0] OFS_ENSET = 16'h0100;
   localparam logic [15:0] OFS_ENCLR = 16'h0180;
   localparam logic [15:0] OFS_PEND  = 16'h0D80;
   localparam logic [15:0] OFS_WAKE  = 16'h0E00;

   typedef enum logic [3:0] {
      RK_NONE,
      RK_CTRL,
      RK_PRIO,
      RK_SYNC,
      RK_HOLD,
      RK_SEL,
      RK_ENSET,
      RK_ENCLR,
      RK_PEND,
      RK_WAKE
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [4:0] bank;
   } reg_sel_t;

   // Decode a byte address into register kind and bank slot
   function automatic reg_sel_t reg_decode(input logic [15:0] a, input int unsigned nb);
      reg_sel_t    d;
      logic [15:0] blk;
      logic        in_rng;
      d.kind = RK_NONE;
      d.bank = 5'd0;
      blk    = {a[15:7], 7'b0};
      in_rng = (32'(a[6:2]) < nb);
      if (a[1:0] == 2'b00) begin
         if      (a == OFS_CTRL) d.kind = RK_CTRL;
         else if (a == OFS_PRIO) d.kind = RK_PRIO;
         else if (a == OFS_SYNC) d.kind = RK_SYNC;
         else if (a == OFS_HOLD) d.kind = RK_HOLD;
         else if (in_rng) begin
            if      (blk == OFS_SEL)   d.kind = RK_SEL;
            else if (blk == OFS_ENSET) d.kind = RK_ENSET;
            else if (blk == OFS_ENCLR) d.kind = RK_ENCLR;
            else if (blk == OFS_PEND)  d.kind = RK_PEND;
            else if (blk == OFS_WAKE)  d.kind = RK_WAKE;
            if (d.kind != RK_NONE) d.bank = a[6:2];
         end
      end
      return d;
   endfunction

endpackage

// File: rtl/bintc_sync.sv
`timescale 1ns/1ps
module bintc_sync #(
   parameter int unsigned WIDTH  = 128,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("bintc_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign dout = stg[STAGES-1];

endmodule

// File: rtl/bintc_bank.sv
`timescale 1ns/1ps
module bintc_bank #(
   parameter int unsigned BANK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] src_sync_i,
   input  logic [BANK_W-1:0] wdata_i,
   input  logic              set_en_i,
   input  logic              clr_en_i,
   input  logic              wr_route_i,
   input  logic              wr_wmask_i,
   output logic [BANK_W-1:0] enable_o,
   output logic [BANK_W-1:0] route_o,
   output logic [BANK_W-1:0] wmask_o,
   output logic [BANK_W-1:0] pend_o,
   output logic              irq_hit_o,
   output logic              fiq_hit_o,
   output logic              wake_hit_o
);

   logic [BANK_W-1:0] enable_q, enable_nxt;
   logic [BANK_W-1:0] route_q;
   logic [BANK_W-1:0] wmask_q;

   always_comb begin
      enable_nxt = enable_q;
      if (set_en_i) enable_nxt = enable_nxt | wdata_i;
      if (clr_en_i) enable_nxt = enable_nxt & ~wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
         route_q  <= '1;
         wmask_q  <= '0;
      end else begin
         enable_q <= enable_nxt;
         if (wr_route_i) route_q <= wdata_i;
         if (wr_wmask_i) wmask_q <= wdata_i;
      end
   end

   assign pend_o     = src_sync_i & enable_q;
   assign irq_hit_o  = |(pend_o & route_q);
   assign fiq_hit_o  = |(pend_o & ~route_q);
   assign wake_hit_o = |(src_sync_i & wmask_q);
   assign enable_o   = enable_q;
   assign route_o    = route_q;
   assign wmask_o    = wmask_q;

endmodule

// File: rtl/bintc_glob.sv
`timescale 1ns/1ps
module bintc_glob
   import bintc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  reg_kind_e         kind_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] ctrl_o,
   output logic [DATA_W-1:0] prio_o,
   output logic [DATA_W-1:0] syncc_o,
   output logic              hold_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_o  <= '0;
         prio_o  <= '0;
         syncc_o <= '0;
         hold_o  <= 1'b0;
      end else if (we_i) begin
         case (kind_i)
            RK_CTRL: ctrl_o  <= wdata_i;
            RK_PRIO: prio_o  <= wdata_i;
            RK_SYNC: syncc_o <= wdata_i;
            RK_HOLD: hold_o  <= wdata_i[0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/banked_intc.sv
`timescale 1ns/1ps
module banked_intc
   import bintc_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 4,
   parameter int unsigned BANK_W      = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NUM_SRC    = NUM_BANKS * BANK_W,
   localparam int unsigned DATA_W     = BANK_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   input  logic               reg_we,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_SRC-1:0] src_i,
   output logic               irq_o,
   output logic               fiq_o,
   output logic               wake_o
);

   if (NUM_BANKS < 1 || NUM_BANKS > 32) begin : g_bad_banks
      $error("banked_intc: NUM_BANKS must lie in 1..32");
   end
   if (BANK_W < 1 || BANK_W > 32) begin : g_bad_width
      $error("banked_intc: BANK_W must lie in 1..32");
   end
   if (ADDR_W < 12 || ADDR_W > 16) begin : g_bad_addr
      $error("banked_intc: ADDR_W must lie in 12..16");
   end

   reg_sel_t dec;
   assign dec = reg_decode(16'(reg_addr), NUM_BANKS);

   logic [NUM_SRC-1:0] src_sync;

   bintc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (src_i),
      .dout (src_sync)
   );

   logic [DATA_W-1:0] ctrl_q, prio_q, syncc_q;
   logic              hold_q;

   bintc_glob #(.DATA_W(DATA_W)) u_glob (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (reg_we),
      .kind_i (dec.kind),
      .wdata_i(reg_wdata),
      .ctrl_o (ctrl_q),
      .prio_o (prio_q),
      .syncc_o(syncc_q),
      .hold_o (hold_q)
   );

   logic [BANK_W-1:0]  bk_en   [NUM_BANKS];
   logic [BANK_W-1:0]  bk_rt   [NUM_BANKS];
   logic [BANK_W-1:0]  bk_wm   [NUM_BANKS];
   logic [BANK_W-1:0]  bk_pend [NUM_BANKS];
   logic [NUM_BANKS-1:0] irq_hit, fiq_hit, wake_hit;
   logic [NUM_SRC-1:0] en_flat, sel_flat, pend_flat;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (dec.bank == 5'(b)) && reg_we;

      bintc_bank #(.BANK_W(BANK_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_sync_i(src_sync[b*BANK_W +: BANK_W]),
         .wdata_i   (reg_wdata),
         .set_en_i  (hit && dec.kind == RK_ENSET),
         .clr_en_i  (hit && dec.kind == RK_ENCLR),
         .wr_route_i(hit && dec.kind == RK_SEL),
         .wr_wmask_i(hit && dec.kind == RK_WAKE),
         .enable_o  (bk_en[b]),
         .route_o   (bk_rt[b]),
         .wmask_o   (bk_wm[b]),
         .pend_o    (bk_pend[b]),
         .irq_hit_o (irq_hit[b]),
         .fiq_hit_o (fiq_hit[b]),
         .wake_hit_o(wake_hit[b])
      );

      assign en_flat  [b*BANK_W +: BANK_W] = bk_en[b];
      assign sel_flat [b*BANK_W +: BANK_W] = bk_rt[b];
      assign pend_flat[b*BANK_W +: BANK_W] = bk_pend[b];
   end

   // Read mux: global registers, then the addressed bank slot
   always_comb begin
      reg_rdata = '0;
      case (dec.kind)
         RK_CTRL: reg_rdata = ctrl_q;
         RK_PRIO: reg_rdata = prio_q;
         RK_SYNC: reg_rdata = syncc_q;
         RK_HOLD: reg_rdata = DATA_W'(hold_q);
         default: begin
            for (int b = 0; b < NUM_BANKS; b++) begin
               if (dec.bank == 5'(b)) begin
                  case (dec.kind)
                     RK_SEL:   reg_rdata = bk_rt[b];
                     RK_ENSET,
                     RK_ENCLR: reg_rdata = bk_en[b];
                     RK_PEND:  reg_rdata = bk_pend[b];
                     RK_WAKE:  reg_rdata = bk_wm[b];
                     default:  ;
                  endcase
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o  <= 1'b0;
         fiq_o  <= 1'b0;
         wake_o <= 1'b0;
      end else begin
         irq_o  <= |irq_hit;
         fiq_o  <= |fiq_hit;
         wake_o <= hold_q && (|wake_hit);
      end
   end

endmodule

// File: rtl/bintc_chk.sv
`timescale 1ns/1ps
module bintc_chk
   import bintc_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned BANK_W    = 32,
   parameter int unsigned ADDR_W    = 12,
   localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic [BANK_W-1:0]  reg_wdata,
   input logic               reg_we,
   input logic [NUM_SRC-1:0] en_flat,
   input logic [NUM_SRC-1:0] sel_flat,
   input logic [NUM_SRC-1:0] pend_flat,
   input logic               hold_q,
   input logic               irq_o,
   input logic               fiq_o,
   input logic               wake_o
);

   reg_sel_t           d;
   logic [NUM_SRC-1:0] wide;
   assign d    = reg_decode(16'(reg_addr), NUM_BANKS);
   assign wide = NUM_SRC'(reg_wdata) << (32'(d.bank) * BANK_W);

   // R2: bits written 1 to the set register are enabled afterwards
   p_enset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && d.kind == RK_ENSET) |=> ((en_flat & $past(wide)) == $past(wide)));

   // R3: bits written 1 to the clear register are disabled afterwards
   p_enclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && d.kind == RK_ENCLR) |=> ((en_flat & $past(wide)) == '0));

   // R5: normal request follows routed pending one cycle later
   p_irq_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == $past(|(pend_flat & sel_flat)));

   // R6: fast request follows fast-routed pending one cycle later
   p_fiq_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fiq_o == $past(|(pend_flat & ~sel_flat)));

   // R8: writing bit 0 high arms holdoff
   p_hold_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && d.kind == RK_HOLD && reg_wdata[0]) |=> hold_q);

   // R9: wake request only while holdoff was armed
   p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> $past(hold_q));

endmodule

bind banked_intc bintc_chk #(
   .NUM_BANKS(NUM_BANKS),
   .BANK_W   (BANK_W),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .reg_we   (reg_we),
   .en_flat  (en_flat),
   .sel_flat (sel_flat),
   .pend_flat(pend_flat),
   .hold_q   (hold_q),
   .irq_o    (irq_o),
   .fiq_o    (fiq_o),
   .wake_o   (wake_o)
);

// File: tb/banked_intc_tb.sv
`timescale 1ns/1ps
module banked_intc_tb;

   localparam int NB = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [11:0]  addr = '0;
   logic [31:0]  wdata = '0;
   logic         we = 1'b0;
   logic [31:0]  rdata;
   logic [127:0] src = '0;
   logic         irq, fiq, wake;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0]  m_en [NB];
   logic [31:0]  m_sel[NB];
   logic [31:0]  m_wk [NB];
   logic         m_hold;
   logic [127:0] m_src;

   always #10 clk = ~clk;

   banked_intc u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_addr (addr),
      .reg_wdata(wdata),
      .reg_we   (we),
      .reg_rdata(rdata),
      .src_i    (src),
      .irq_o    (irq),
      .fiq_o    (fiq),
      .wake_o   (wake)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
   endtask

   function automatic logic [31:0] exp_pend(input int b);
      return m_src[b*32 +: 32] & m_en[b];
   endfunction

   function automatic logic exp_irq();
      logic r = 1'b0;
      for (int b = 0; b < NB; b++) r |= |(exp_pend(b) & m_sel[b]);
      return r;
   endfunction

   function automatic logic exp_fiq();
      logic r = 1'b0;
      for (int b = 0; b < NB; b++) r |= |(exp_pend(b) & ~m_sel[b]);
      return r;
   endfunction

   function automatic logic exp_wake();
      logic r = 1'b0;
      for (int b = 0; b < NB; b++) r |= |(m_src[b*32 +: 32] & m_wk[b]);
      return m_hold & r;
   endfunction

   task automatic settle_and_check();
      logic [31:0] d;
      src = m_src;
      repeat (3) @(negedge clk);
      #1;
      chk("R5 irq_o", 32'(irq), 32'(exp_irq()));
      chk("R6 fiq_o", 32'(fiq), 32'(exp_fiq()));
      chk("R9 wake_o", 32'(wake), 32'(exp_wake()));
      for (int b = 0; b < NB; b++) begin
         rd(12'hD80 + 12'(4*b), d); chk("R1 pending", d, exp_pend(b));
         rd(12'h100 + 12'(4*b), d); chk("R2 enable read", d, m_en[b]);
         rd(12'h080 + 12'(4*b), d); chk("R4 route read", d, m_sel[b]);
         rd(12'hE00 + 12'(4*b), d); chk("R7 wake mask", d, m_wk[b]);
      end
      rd(12'h014, d); chk("R8 holdoff read", d, 32'(m_hold));
   endtask

   initial begin
      #3000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h5EED_1234));
      for (int b = 0; b < NB; b++) begin
         m_en[b] = '0; m_sel[b] = '1; m_wk[b] = '0;
      end
      m_hold = 1'b0;
      m_src  = '0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R12 / R4 / R10: reset state
      #1;
      chk("R12 irq reset", 32'(irq), 0);
      chk("R12 fiq reset", 32'(fiq), 0);
      chk("R12 wake reset", 32'(wake), 0);
      for (int b = 0; b < NB; b++) begin
         rd(12'h100 + 12'(4*b), d); chk("R12 enable reset", d, 0);
         rd(12'h080 + 12'(4*b), d); chk("R4 route reset", d, 32'hFFFF_FFFF);
         rd(12'hE00 + 12'(4*b), d); chk("R12 wake mask reset", d, 0);
      end
      rd(12'h014, d); chk("R12 holdoff reset", d, 0);
      rd(12'h000, d); chk("R10 ctrl reset", d, 0);

      // R10: global storage read-back
      wr(12'h000, 32'h8001_0001);
      wr(12'h00C, 32'h0000_001F);
      wr(12'h010, 32'h0000_0002);
      rd(12'h000, d); chk("R10 ctrl", d, 32'h8001_0001);
      rd(12'h00C, d); chk("R10 prio", d, 32'h0000_001F);
      rd(12'h010, d); chk("R10 syncc", d, 32'h0000_0002);

      // R2 / R3: zero bits ignored
      wr(12'h104, 32'h0000_00F0); m_en[1] = 32'hF0;
      wr(12'h104, 32'h0000_000F); m_en[1] = 32'hFF;
      rd(12'h104, d); chk("R2 set keeps zeros", d, 32'hFF);
      wr(12'h184, 32'h0000_003C); m_en[1] = 32'hC3;
      rd(12'h184, d); chk("R3 clear keeps zeros", d, 32'hC3);

      // R11: unmapped offsets
      rd(12'h004, d); chk("R11 gap read", d, 0);
      rd(12'h110, d); chk("R11 bank slot out of range", d, 0);
      rd(12'h105, d); chk("R11 misaligned", d, 0);
      wr(12'h110, 32'hFFFF_FFFF);
      wr(12'h105, 32'hFFFF_FFFF);
      wr(12'h200, 32'hFFFF_FFFF);
      for (int b = 0; b < NB; b++) begin
         rd(12'h100 + 12'(4*b), d); chk("R11 write no effect", d, m_en[b]);
      end

      // R1 / R5: synchronizer latency on source 5
      wr(12'h100, 32'h0000_0020); m_en[0] = 32'h20;
      @(negedge clk);
      addr = 12'hD80;
      src[5] = 1'b1; m_src[5] = 1'b1;
      @(negedge clk); #1;
      chk("R1 pending after one edge", rdata, 0);
      @(negedge clk); #1;
      chk("R1 pending after two edges", rdata, 32'h20);
      chk("R5 irq not yet", 32'(irq), 0);
      @(negedge clk); #1;
      chk("R5 irq after three edges", 32'(irq), 1);
      chk("R6 fiq quiet for normal route", 32'(fiq), 0);

      // R6: source 32 routed to fast output
      wr(12'h084, 32'hFFFF_FFFE); m_sel[1] = 32'hFFFF_FFFE;
      wr(12'h104, 32'h0000_0001); m_en[1] = m_en[1] | 32'h1;
      m_src[5] = 1'b0; m_src[32] = 1'b1;
      settle_and_check();
      chk("R6 fast only", {30'b0, irq, fiq}, 32'b01);

      // R8 / R9: holdoff gating of wake
      wr(12'hE08, 32'h0000_0100); m_wk[2] = 32'h100;
      m_src[72] = 1'b1;
      settle_and_check();
      chk("R9 no wake without holdoff", 32'(wake), 0);
      wr(12'h014, 32'h1); m_hold = 1'b1;
      settle_and_check();
      chk("R9 wake armed", 32'(wake), 1);
      wr(12'h014, 32'h0); m_hold = 1'b0;
      settle_and_check();
      chk("R8 holdoff cleared", 32'(wake), 0);

      // Random mix
      for (int it = 0; it < 80; it++) begin
         int          op = int'($urandom % 6);
         int          b  = int'($urandom % NB);
         logic [31:0] v  = $urandom;
         case (op)
            0: begin wr(12'h100 + 12'(4*b), v); m_en[b] |= v; end
            1: begin wr(12'h180 + 12'(4*b), v); m_en[b] &= ~v; end
            2: begin wr(12'h080 + 12'(4*b), v); m_sel[b] = v; end
            3: begin wr(12'hE00 + 12'(4*b), v); m_wk[b] = v; end
            4: begin wr(12'h014, v); m_hold = v[0]; end
            default: m_src[b*32 +: 32] = v;
         endcase
         settle_and_check();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule